// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside an 8-bit CPU core and decides, once per instruction, whether the core should divert to an interrupt. Five sources are arbitrated. The first is a non-maskable request (NMI). Next come three restart requests that jump to fixed internal vectors: one edge-triggered source and two level-sensitive sources. The last is a general request that needs an opcode supplied from outside. Requests are only examined when the core pulses a sample strobe near the end of an instruction. The highest-ranked eligible request wins. The next cycle carries a take pulse, a one-hot source indication and a 16-bit restart vector. For the general request, the vector is replaced by an acknowledge and a hold on the program counter, so an external device can drive a restart or call opcode.

Software controls the block through enable and disable strobes for a global enable flag, and through a mask-write word. Bits 2:0 are the masks for the low-level, high-level and edge restarts. Bit 3 must be 1 for the masks to change. Bit 4 discards a latched edge event. A status word can be read back at any time.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset `take_o`, `ext_ack_o`, `pc_hold_o` and `take_src_o` are 0, `vector_o` is 0x0000, the global enable is 0 and all three restart masks are 1.
- R2: Fixed priority, from highest to lowest: NMI (take_src bit 0), edge restart (bit 1), high-level restart (bit 2), low-level restart (bit 3), general request (bit 4). Exactly one source is taken per accepted sample.
- R3: NMI is taken whenever it is high at a sample, whatever the global enable and the masks hold.
- R4: Requests are examined only in a cycle with `sample_i` high. `take_o` pulses for one cycle, in the cycle after the sample.
- R5: Vectors: NMI 0x0024, edge restart 0x003C, high-level restart 0x0034, low-level restart 0x002C.
- R6: When the general request wins, `ext_ack_o` and `pc_hold_o` pulse together with `take_o`, and `vector_o` is 0x0000. A restart source asserts neither of them.
- R7: Any accepted interrupt clears the global enable. `ei_i` sets it and `di_i` clears it. In the same cycle, acceptance overrides both, and disable overrides enable.
- R8: A mask write with bit 3 = 0 leaves the masks unchanged. With bit 3 = 1, mask bits 2:0 (edge, high-level, low-level) are loaded from data bits 2:0.
- R9: A maskable source is taken only if the global enable is 1 and its own mask bit is 0. The general request needs only the enable.
- R10: A rising edge on the edge restart pin is latched. The latch stays pending until that source is taken, or until a mask write with bit 4 = 1 arrives, whatever bit 3 holds. A pin held high does not set it again. A new edge in the same cycle as a clear wins.
- R11: The high-level and low-level restarts count only while their pin is high in the sample cycle.
- R12: Status word: bit 7 serial input pin, bit 6 edge latch, bit 5 high-level pin, bit 4 low-level pin, bit 3 global enable, bits 2:0 masks (edge, high-level, low-level).
- R13: Reset clears the edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request |
| edge_irq_i | input | 1 | Edge-triggered restart request |
| lvl_hi_irq_i | input | 1 | Level-sensitive restart, higher rank |
| lvl_lo_irq_i | input | 1 | Level-sensitive restart, lower rank |
| gen_req_i | input | 1 | General request needing an external opcode |
| ei_i | input | 1 | Set the global enable |
| di_i | input | 1 | Clear the global enable |
| sample_i | input | 1 | Instruction-boundary sample strobe |
| mask_wr_i | input | 1 | Mask-word write strobe |
| mask_wdata_i | input | 8 | Mask word |
| serial_in_i | input | 1 | Serial input bit reported in the status word |
| rd_word_o | output | 8 | Status readback word |
| take_o | output | 1 | Interrupt accepted, one-cycle pulse |
| take_src_o | output | 5 | One-hot winning source |
| vector_o | output | 16 | Restart address of the winner |
| ext_ack_o | output | 1 | Acknowledge for the external opcode |
| pc_hold_o | output | 1 | Program counter must not advance |

## Verification
A wrong arbitration state shows up in the cycle after the sample. It appears as a wrong one-hot source, a wrong vector or a missing acknowledge. The bench sweeps every combination of pending sources against every mask setting, with the enable both on and off. A stale or lost edge latch is invisible until the next sample. The status word exposes it right away, so the bench reads it back after each accept and after each clear. A global enable left set after an accept would let a nested interrupt through at the next sample. This is also caught through bit 3 in the cycle right after the take.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 5;
  localparam int NMASK  = 3;
  localparam int VEC_W  = 16;
  localparam int WORD_W = 8;

  localparam int S_NMI  = 0;
  localparam int S_EDGE = 1;
  localparam int S_LVLH = 2;
  localparam int S_LVLL = 3;
  localparam int S_GEN  = 4;

  // mask-write word fields
  localparam int MW_LVLL = 0;
  localparam int MW_LVLH = 1;
  localparam int MW_EDGE = 2;
  localparam int MW_MSE  = 3;
  localparam int MW_CLRE = 4;

  localparam logic [VEC_W-1:0] V_NMI  = 16'h0024;
  localparam logic [VEC_W-1:0] V_EDGE = 16'h003C;
  localparam logic [VEC_W-1:0] V_LVLH = 16'h0034;
  localparam logic [VEC_W-1:0] V_LVLL = 16'h002C;

  function automatic logic [VEC_W-1:0] vec_of(input logic [NSRC-1:0] grant);
    logic [VEC_W-1:0] v;
    v = '0;
    if (grant[S_NMI])  v = V_NMI;
    if (grant[S_EDGE]) v = V_EDGE;
    if (grant[S_LVLH]) v = V_LVLH;
    if (grant[S_LVLL]) v = V_LVLL;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
      input logic si, input logic pe, input logic ph, input logic pl,
      input logic ie, input logic [NMASK-1:0] m);
    return {si, pe, ph, pl, ie, m};
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic rise_o,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;

  assign rise_o = pin_i & ~prev_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (rise_o)     pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              accept_i,
  output logic [NMASK-1:0]  mask_o,
  output logic              ie_o,
  output logic              clr_edge_o
);
  logic [NMASK-1:0] mask_q;
  logic             ie_q;
  logic             mask_load_w;

  assign mask_load_w = wr_i & wdata_i[MW_MSE];
  assign clr_edge_o  = wr_i & wdata_i[MW_CLRE];
  assign mask_o      = mask_q;
  assign ie_o        = ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (mask_load_w) mask_q <= wdata_i[NMASK-1:0];
      if (accept_i)  ie_q <= 1'b0;
      else if (di_i) ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rank
      if (gi == 0) begin : g_top
        assign grant_o[gi] = req_i[gi];
      end else begin : g_rest
        assign grant_o[gi] = req_i[gi] & ~(|req_i[gi-1:0]);
      end
    end
  endgenerate
  assign any_o = |req_i;
endmodule

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              edge_irq_i,
  input  logic              lvl_hi_irq_i,
  input  logic              lvl_lo_irq_i,
  input  logic              gen_req_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              sample_i,
  input  logic              mask_wr_i,
  input  logic [WORD_W-1:0] mask_wdata_i,
  input  logic              serial_in_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              take_o,
  output logic [NSRC-1:0]   take_src_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              ext_ack_o,
  output logic              pc_hold_o
);
  logic [NMASK-1:0] mask_w;
  logic             ie_w;
  logic             clr_edge_sw_w;
  logic             edge_pend_w;
  logic             edge_rise_w;
  logic [NSRC-1:0]  qual_w;
  logic [NSRC-1:0]  grant_w;
  logic             any_w;
  logic             accept_w;
  logic             edge_taken_w;

  logic             take_q;
  logic [NSRC-1:0]  src_q;
  logic [VEC_W-1:0] vec_q;
  logic             ack_q;

  irq_mask_bank u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (mask_wr_i),
    .wdata_i   (mask_wdata_i),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .accept_i  (accept_w),
    .mask_o    (mask_w),
    .ie_o      (ie_w),
    .clr_edge_o(clr_edge_sw_w)
  );

  assign edge_taken_w = accept_w & grant_w[S_EDGE];

  irq_edge_latch u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (edge_irq_i),
    .clr_i (clr_edge_sw_w | edge_taken_w),
    .rise_o(edge_rise_w),
    .pend_o(edge_pend_w)
  );

  always_comb begin
    qual_w         = '0;
    qual_w[S_NMI]  = nmi_i;
    qual_w[S_EDGE] = edge_pend_w  & ~mask_w[MW_EDGE] & ie_w;
    qual_w[S_LVLH] = lvl_hi_irq_i & ~mask_w[MW_LVLH] & ie_w;
    qual_w[S_LVLL] = lvl_lo_irq_i & ~mask_w[MW_LVLL] & ie_w;
    qual_w[S_GEN]  = gen_req_i    & ie_w;
  end

  irq_prio_arb #(.N(NSRC)) u_arb (
    .req_i  (qual_w),
    .grant_o(grant_w),
    .any_o  (any_w)
  );

  assign accept_w = sample_i & any_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      take_q <= accept_w;
      src_q  <= accept_w ? grant_w : '0;
      vec_q  <= accept_w ? vec_of(grant_w) : '0;
      ack_q  <= accept_w & grant_w[S_GEN];
    end
  end

  assign take_o     = take_q;
  assign take_src_o = src_q;
  assign vector_o   = vec_q;
  assign ext_ack_o  = ack_q;
  assign pc_hold_o  = ack_q;
  assign rd_word_o  = pack_status(serial_in_i, edge_pend_w, lvl_hi_irq_i,
                                  lvl_lo_irq_i, ie_w, mask_w);
endmodule

// File: rtl/irq_restart_ctrl_chk.sv
module irq_restart_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_i,
  input logic              sample_i,
  input logic              mask_wr_i,
  input logic [WORD_W-1:0] mask_wdata_i,
  input logic [WORD_W-1:0] rd_word_o,
  input logic              take_o,
  input logic [NSRC-1:0]   take_src_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic              ext_ack_o,
  input logic              pc_hold_o,
  input logic              accept_w
);
  AST_TAKE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i)); // R4
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_src_o) && (take_o == (take_src_o != '0))); // R2
  AST_NMI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && nmi_i) |=> take_src_o[S_NMI]); // R3
  AST_EDGE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_src_o[S_EDGE] |-> vector_o == 16'h003C); // R5
  AST_ACK_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack_o |-> (take_o && vector_o == '0 && pc_hold_o)); // R6
  AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !rd_word_o[3]); // R7
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !mask_wdata_i[MW_MSE]) |=> $stable(rd_word_o[2:0])); // R8
  AST_DISABLED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !nmi_i && !rd_word_o[3]) |=> !take_o); // R9
endmodule

bind irq_restart_ctrl irq_restart_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_i       (nmi_i),
  .sample_i    (sample_i),
  .mask_wr_i   (mask_wr_i),
  .mask_wdata_i(mask_wdata_i),
  .rd_word_o   (rd_word_o),
  .take_o      (take_o),
  .take_src_o  (take_src_o),
  .vector_o    (vector_o),
  .ext_ack_o   (ext_ack_o),
  .pc_hold_o   (pc_hold_o),
  .accept_w    (accept_w)
);

// File: tb/irq_restart_ctrl_tb.sv
module irq_restart_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, edg = 0, lh = 0, ll = 0, gen = 0, ei = 0, di = 0, smp = 0;
  logic mwr = 0;
  logic [7:0] mwd = '0;
  logic si = 0;
  logic [7:0] rd;
  logic take;
  logic [4:0] src;
  logic [15:0] vec;
  logic ack, hold;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_restart_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .edge_irq_i(edg),
    .lvl_hi_irq_i(lh), .lvl_lo_irq_i(ll), .gen_req_i(gen),
    .ei_i(ei), .di_i(di), .sample_i(smp), .mask_wr_i(mwr),
    .mask_wdata_i(mwd), .serial_in_i(si), .rd_word_o(rd),
    .take_o(take), .take_src_o(src), .vector_o(vec),
    .ext_ack_o(ack), .pc_hold_o(hold)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic do_sample(); smp = 1; step(); smp = 0; endtask
  task automatic wr_mask(input logic [7:0] w); mwr = 1; mwd = w; step(); mwr = 0; mwd = '0; endtask
  task automatic do_ei(); ei = 1; step(); ei = 0; endtask
  task automatic do_di(); di = 1; step(); di = 0; endtask

  function automatic logic [15:0] exp_vec(input int w);
    case (w)
      0: return 16'h0024;
      1: return 16'h003C;
      2: return 16'h0034;
      3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 R13 R12 reset state
    chk(take == 0 && ack == 0 && hold == 0 && src == 0, "R1 idle outputs", {take, ack, hold, src}, 0);
    chk(vec == 16'h0000, "R1 vector", vec, 0);
    chk(rd == 8'h07, "R13 R12 status after reset", rd, 8'h07);
    si = 1; step();
    chk(rd[7] == 1, "R12 serial bit", rd, 8'h87);
    si = 0;

    // R4: no sample, no take
    nmi = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(take == 0, "R4 no take without sample", take, 0);
    end
    nmi = 0;

    // R8 mask write without enable bit ignored
    wr_mask(8'h00);
    chk(rd[2:0] == 3'b111, "R8 masks held", rd[2:0], 3'b111);
    wr_mask(8'h0A);
    chk(rd[2:0] == 3'b010, "R8 masks loaded", rd[2:0], 3'b010);

    // Near-exhaustive sweep: enable x masks x pending set
    for (int ie = 0; ie < 2; ie++) begin
      for (int m = 0; m < 8; m++) begin
        for (int c = 0; c < 32; c++) begin
          logic [4:0] el;
          int win;
          edg = 0;
          wr_mask(8'h18 | m[7:0]);
          if (ie != 0) do_ei(); else do_di();
          if (c[1]) begin edg = 1; step(); edg = 0; step(); end
          nmi = c[0]; lh = c[2]; ll = c[3]; gen = c[4];
          el[0] = c[0];
          el[1] = c[1] && ie != 0 && !m[2];
          el[2] = c[2] && ie != 0 && !m[1];
          el[3] = c[3] && ie != 0 && !m[0];
          el[4] = c[4] && ie != 0;
          win = 5;
          for (int b = 4; b >= 0; b--) if (el[b]) win = b;
          do_sample();
          if (win == 5) begin
            chk(take == 0 && src == 0, "R9 R11 nothing eligible", {take, src}, 0);
            chk(rd[3] == ie[0], "R7 enable kept", rd[3], ie[0]);
          end else begin
            chk(take == 1, "R2 take", take, 1);
            chk(src == (5'd1 << win), "R2 R3 R9 winner", src, 5'd1 << win);
            chk(vec == exp_vec(win), "R5 vector", vec, exp_vec(win));
            chk(ack == (win == 4) && hold == (win == 4), "R6 ack/hold", {ack, hold}, {win == 4, win == 4});
            chk(rd[3] == 0, "R7 enable cleared by accept", rd[3], 0);
          end
          chk(rd[6] == (c[1] && win != 1), "R10 edge latch after sample", rd[6], c[1] && win != 1);
          nmi = 0; lh = 0; ll = 0; gen = 0;
          step();
          chk(take == 0, "R4 single-cycle take", take, 0);
        end
      end
    end

    // R10: level held after service does not retrigger
    wr_mask(8'h18);
    do_ei();
    edg = 1; step(); step();
    do_sample();
    chk(take == 1 && vec == 16'h003C, "R10 edge taken", vec, 16'h003C);
    do_ei(); step();
    do_sample();
    chk(take == 0 && rd[6] == 0, "R10 held level no retrigger", {take, rd[6]}, 0);
    edg = 0; step();
    // R10: clear bit with enable bit 0
    edg = 1; step(); edg = 0; step();
    chk(rd[6] == 1, "R10 edge latched", rd[6], 1);
    wr_mask(8'h10);
    chk(rd[6] == 0 && rd[2:0] == 3'b000, "R10 clear bit", rd, 8'h08);
    // R10: edge and clear same cycle
    edg = 1; wr_mask(8'h10); edg = 0;
    chk(rd[6] == 1, "R10 edge beats clear", rd[6], 1);
    wr_mask(8'h10);

    // R7 ordering
    do_di();
    ei = 1; di = 1; step(); ei = 0; di = 0;
    chk(rd[3] == 0, "R7 disable beats enable", rd[3], 0);
    do_ei();
    chk(rd[3] == 1, "R7 enable sets", rd[3], 1);
    nmi = 1; ei = 1; smp = 1; step(); ei = 0; smp = 0; nmi = 0;
    chk(take == 1 && rd[3] == 0, "R7 accept beats enable", {take, rd[3]}, 2'b10);

    // R11: level dropped before sample
    do_ei();
    ll = 1; step(); ll = 0;
    do_sample();
    chk(take == 0, "R11 level gone", take, 0);
    lh = 1; do_sample(); lh = 0;
    chk(take == 1 && vec == 16'h0034, "R11 level present", vec, 16'h0034);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule